// File: doc/BRIEF.md
# Watchdog Timer with Keyed Stop/Start Control

This block is a watchdog timer that sits on a plain memory-mapped register port. It leaves reset already enabled and counting up from a default load value. If the counter wraps past its all-ones value while the watchdog is enabled, the block raises a system reset request for a fixed number of cycles. It then reloads the counter and keeps running. Software keeps the system alive by writing the trigger register, which reloads the counter from the load register.

The watchdog can be stopped or restarted only by an ordered pair of key words written to the key register. Writes to the key, load and trigger registers are posted. Each one passes through a fixed-latency synchronisation stage before it takes effect. While a write is in flight, a per-register pending flag in the status register stays set, and another write to that register is dropped. Software polls the flag before it issues the next write. The key tracker is a small state machine with three states:

- `KS_IDLE`: no key word is held.
- `KS_DIS_ARMED`: the first stop word has arrived.
- `KS_EN_ARMED`: the first start word has arrived.

Its transitions are as follows:

- `KS_IDLE` moves to `KS_DIS_ARMED` on 0x0000AAAA.
- `KS_IDLE` moves to `KS_EN_ARMED` on 0x0000BBBB.
- `KS_IDLE` stays in `KS_IDLE` on any other word.
- `KS_DIS_ARMED` returns to `KS_IDLE` on 0x00005555 and stops the counter.
- `KS_EN_ARMED` returns to `KS_IDLE` on 0x00004444 and starts the counter.
- Either armed state returns to `KS_IDLE` on any other word, with no change to the enable.

Top module: `wdt_keyctl`

## Requirements
- R1: After reset the watchdog is enabled, the counter and the load register (offset 0x2C) hold 0xFFFB0000, the status register reads 0 and `rst_req` is low.
- R2: While enabled, the counter (readable at offset 0x28) increases by one on each divider tick. With the default divider, a tick comes on every clock.
- R3: The status register at offset 0x34 has three pending flags: bit 4 for the key register, bit 3 for the trigger register and bit 2 for the load register. An accepted write sets its flag for exactly 3 cycles, and the write takes effect on the edge that clears the flag.
- R4: A write to a posted register while its pending flag is set is ignored. It does not change that register's applied value or the key state.
- R5: Writing 0x0000AAAA to the key register (offset 0x48), and then, as a separate write, 0x00005555, stops the counter. The counter value then holds.
- R6: In an armed state, any applied key word other than the matching second word returns the tracker to `KS_IDLE` and leaves the enable unchanged. A second word in `KS_IDLE` has no effect.
- R7: Writing 0x0000BBBB and then 0x00004444 to the key register restarts a stopped counter from its held value.
- R8: If the counter wraps past 0xFFFFFFFF while enabled, `rst_req` is high for exactly 4 cycles starting on the wrap edge. The counter is reloaded from the load register on that edge and keeps counting.
- R9: While the watchdog is stopped, the counter does not advance and `rst_req` never rises.
- R10: A write to the trigger register (offset 0x30) reloads the counter from the load register. A load write changes only the load register and not the counter.
- R11: The key register reads back the last applied key word. The trigger register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | System reset request pulse |

## Verification
The bench sends a second key word while the first is still pending. A design that queued or accepted that write would stop the watchdog too early, and the key readback would show the wrong word. It sends a wrong word between the stop key words and a stray start word after a stop word. A tracker that stayed armed would then disable or enable on a broken sequence. It measures the pending flag length and the exact wrap edge against a counter snapshot. An off-by-one in the synchroniser, or a reset pulse that is too short or not followed by a reload, shows up as a pulse in the wrong cycle. With the watchdog stopped and a near-wrap load value, it checks that no reset request appears.

// File: rtl/wdt_keyctl_pkg.sv
package wdt_keyctl_pkg;

    // register byte offsets
    localparam logic [7:0] OFS_COUNT = 8'h28;
    localparam logic [7:0] OFS_LOAD  = 8'h2C;
    localparam logic [7:0] OFS_TRIG  = 8'h30;
    localparam logic [7:0] OFS_STAT  = 8'h34;
    localparam logic [7:0] OFS_KEY   = 8'h48;

    // status flag positions
    localparam int unsigned STAT_LOAD_BIT = 2;
    localparam int unsigned STAT_TRIG_BIT = 3;
    localparam int unsigned STAT_KEY_BIT  = 4;

    // key words
    localparam logic [31:0] KEY_STOP_1  = 32'h0000_AAAA;
    localparam logic [31:0] KEY_STOP_2  = 32'h0000_5555;
    localparam logic [31:0] KEY_START_1 = 32'h0000_BBBB;
    localparam logic [31:0] KEY_START_2 = 32'h0000_4444;

    typedef enum logic [1:0] {
        KS_IDLE      = 2'd0,
        KS_DIS_ARMED = 2'd1,
        KS_EN_ARMED  = 2'd2
    } key_state_e;

endpackage

// File: rtl/wdt_post.sv
module wdt_post #(
    parameter int unsigned DW       = 32,
    parameter int unsigned SYNC_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          pend,
    output logic          apply,
    output logic [DW-1:0] apply_data
);
    localparam int unsigned SCW = $clog2(SYNC_CYC + 1);

    logic          busy;
    logic [SCW-1:0] stage;
    logic [DW-1:0] data_q;
    logic          accept;

    assign accept     = wr_req && !busy;
    assign apply      = busy && (stage == SCW'(SYNC_CYC - 1));
    assign pend       = busy;
    assign apply_data = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            stage  <= '0;
            data_q <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            stage  <= '0;
            data_q <= wr_data;
        end else if (apply) begin
            busy   <= 1'b0;
        end else if (busy) begin
            stage  <= stage + 1'b1;
        end
    end

    // length of the current pending run, for the checks below
    logic [SCW:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R3
    pend_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == (SCW+1)'(SYNC_CYC)));

    // R4
    pend_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_req) |=> $stable(data_q));

endmodule

// File: rtl/wdt_keyfsm.sv
module wdt_keyfsm
    import wdt_keyctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        apply,
    input  logic [31:0] key_word,
    output logic        enable,
    output logic [31:0] key_last
);
    key_state_e state_q, state_d;
    logic       enable_d;
    logic       stop_hit, start_hit;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= KS_IDLE;
            enable   <= 1'b1;
            key_last <= '0;
        end else begin
            state_q  <= state_d;
            enable   <= enable_d;
            if (apply) key_last <= key_word;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (apply) begin
            unique case (state_q)
                KS_IDLE: begin
                    if (key_word == KEY_STOP_1)       state_d = KS_DIS_ARMED;
                    else if (key_word == KEY_START_1) state_d = KS_EN_ARMED;
                    else                              state_d = KS_IDLE;
                end
                KS_DIS_ARMED: state_d = KS_IDLE;
                KS_EN_ARMED:  state_d = KS_IDLE;
                default:      state_d = KS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        stop_hit  = apply && (state_q == KS_DIS_ARMED) && (key_word == KEY_STOP_2);
        start_hit = apply && (state_q == KS_EN_ARMED)  && (key_word == KEY_START_2);
        enable_d  = enable;
        if (stop_hit)  enable_d = 1'b0;
        if (start_hit) enable_d = 1'b1;
    end

    // R5
    stop_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && state_q == KS_DIS_ARMED && key_word == KEY_STOP_2) |=> !enable);

    // R7
    start_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && state_q == KS_EN_ARMED && key_word == KEY_START_2) |=> enable);

    // R6
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && state_q != KS_IDLE && !stop_hit && !start_hit)
            |=> (state_q == KS_IDLE) && (enable == $past(enable)));

endmodule

// File: rtl/wdt_upcount.sv
module wdt_upcount #(
    parameter int unsigned   CW           = 32,
    parameter int unsigned   PRESC_LOG2   = 0,
    parameter int unsigned   RST_CYC      = 4,
    parameter logic [CW-1:0] LOAD_DEFAULT = 32'hFFFB_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          load_apply,
    input  logic [CW-1:0] load_data,
    input  logic          trig_apply,
    output logic [CW-1:0] count,
    output logic [CW-1:0] load_val,
    output logic          rst_req
);
    localparam int unsigned   PW      = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic          tick;
    logic          expire;
    logic [PW-1:0] pls_q;

    generate
        if (PRESC_LOG2 == 0) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [PRESC_LOG2-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_q + 1'b1;
            end
            assign tick = &pre_q;
        end
    endgenerate

    assign expire = enable && tick && (count == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= LOAD_DEFAULT;
        end else if (trig_apply || expire) begin
            count <= load_val;
        end else if (enable && tick) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          load_val <= LOAD_DEFAULT;
        else if (load_apply) load_val <= load_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pls_q <= '0;
        else if (expire)       pls_q <= PW'(RST_CYC);
        else if (pls_q != '0)  pls_q <= pls_q - 1'b1;
    end

    assign rst_req = (pls_q != '0);

    logic [PW:0] hi_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_len <= '0;
        else if (rst_req) hi_len <= hi_len + 1'b1;
        else              hi_len <= '0;
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && !expire && !trig_apply) |=> (count == $past(count) + 1'b1));

    // R8
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (hi_len >= (PW+1)'(RST_CYC)));

    // R8
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (rst_req && count == $past(load_val)));

    // R9
    no_rst_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !$rose(rst_req));

    // R9
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !trig_apply) |=> $stable(count));

endmodule

// File: rtl/wdt_keyctl.sv
module wdt_keyctl
    import wdt_keyctl_pkg::*;
#(
    parameter int unsigned   CW           = 32,
    parameter int unsigned   SYNC_CYC     = 3,
    parameter int unsigned   PRESC_LOG2   = 0,
    parameter int unsigned   RST_CYC      = 4,
    parameter logic [CW-1:0] LOAD_DEFAULT = 32'hFFFB_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic          rst_req
);
    logic          wr_key, wr_load, wr_trig;
    logic          pend_key, pend_load, pend_trig;
    logic          app_key, app_load, app_trig;
    logic [CW-1:0] dat_key, dat_load, dat_trig;
    logic          enable;
    logic [31:0]   key_last;
    logic [CW-1:0] count, load_val;

    assign wr_key  = bus_wr && (bus_addr == OFS_KEY);
    assign wr_load = bus_wr && (bus_addr == OFS_LOAD);
    assign wr_trig = bus_wr && (bus_addr == OFS_TRIG);

    wdt_post #(.DW(CW), .SYNC_CYC(SYNC_CYC)) u_post_key (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_key), .wr_data(bus_wdata),
        .pend(pend_key), .apply(app_key), .apply_data(dat_key));

    wdt_post #(.DW(CW), .SYNC_CYC(SYNC_CYC)) u_post_load (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_load), .wr_data(bus_wdata),
        .pend(pend_load), .apply(app_load), .apply_data(dat_load));

    wdt_post #(.DW(CW), .SYNC_CYC(SYNC_CYC)) u_post_trig (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_trig), .wr_data(bus_wdata),
        .pend(pend_trig), .apply(app_trig), .apply_data(dat_trig));

    wdt_keyfsm u_keyfsm (
        .clk(clk), .rst_n(rst_n), .apply(app_key), .key_word(32'(dat_key)),
        .enable(enable), .key_last(key_last));

    wdt_upcount #(
        .CW(CW), .PRESC_LOG2(PRESC_LOG2), .RST_CYC(RST_CYC), .LOAD_DEFAULT(LOAD_DEFAULT)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .load_apply(app_load), .load_data(dat_load), .trig_apply(app_trig),
        .count(count), .load_val(load_val), .rst_req(rst_req));

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_COUNT: bus_rdata = count;
            OFS_LOAD:  bus_rdata = load_val;
            OFS_KEY:   bus_rdata = CW'(key_last);
            OFS_STAT: begin
                bus_rdata[STAT_LOAD_BIT] = pend_load;
                bus_rdata[STAT_TRIG_BIT] = pend_trig;
                bus_rdata[STAT_KEY_BIT]  = pend_key;
            end
            default:   bus_rdata = '0;
        endcase
    end

    // dat_trig carries no information; the trigger is the write itself
    logic unused_trig;
    assign unused_trig = ^dat_trig;

    // R3
    stat_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key && !pend_key) |=> pend_key);

endmodule

// File: tb/wdt_keyctl_tb.sv
module wdt_keyctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    wdt_keyctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req));

    localparam logic [7:0] A_CNT = 8'h28, A_LOAD = 8'h2C, A_TRIG = 8'h30,
                           A_STAT = 8'h34, A_KEY = 8'h48;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic wait_clear(input int b);
        logic [31:0] s;
        for (int i = 0; i < 20; i++) begin
            rd(A_STAT, s);
            if (!s[b]) break;
            @(negedge clk);
        end
    endtask

    task automatic key(input logic [31:0] d);
        wr(A_KEY, d);
        wait_clear(4);
    endtask

    task automatic running(input string req, input logic exp_run);
        logic [31:0] v1, v2;
        rd(A_CNT, v1);
        repeat (6) @(negedge clk);
        rd(A_CNT, v2);
        chk(req, v2, exp_run ? v1 + 32'd6 : v1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
        rd(A_LOAD, v);  chk("R1 load", v, 32'hFFFB0000);
        rd(A_STAT, v);  chk("R1 status", v, 32'd0);
        rd(A_CNT, v);   chk("R1 count upper", {16'd0, v[31:16]}, 32'h0000FFFB);
        rd(A_TRIG, v);  chk("R11 trig read", v, 32'd0);
        rd(8'h10, v);   chk("R11 unmapped", v, 32'd0);
    endtask

    task automatic t_count();
        running("R2 counting", 1'b1);
    endtask

    task automatic t_pending();
        logic [31:0] s, c;
        int n;
        wr(A_KEY, 32'h1234);
        n = 0;
        rd(A_STAT, s);
        while (s[4] && n < 10) begin n++; @(negedge clk); rd(A_STAT, s); end
        chk("R3 key pend len", n, 3);
        wr(A_TRIG, 32'd0);
        n = 0;
        rd(A_STAT, s);
        while (s[3] && n < 10) begin n++; @(negedge clk); rd(A_STAT, s); end
        chk("R3 trig pend len", n, 3);
        rd(A_CNT, c);
        chk("R10 trig reload", c, 32'hFFFB0000);
        wr(A_LOAD, 32'h0000_0100);
        rd(A_STAT, s);
        chk("R3 load flag", {31'd0, s[2]}, 32'd1);
        wait_clear(2);
        rd(A_LOAD, c);
        chk("R3 load applied", c, 32'h0000_0100);
        rd(A_CNT, c);
        chk("R10 load no reload", {16'd0, c[31:16]}, 32'h0000FFFB);
        wr(A_LOAD, 32'hFFFB0000);
        wait_clear(2);
    endtask

    task automatic t_bad_seq();
        logic [31:0] v;
        key(32'hAAAA);
        key(32'h1234);
        key(32'h5555);
        running("R6 broken stop seq", 1'b1);
        rd(A_KEY, v);
        chk("R11 key readback", v, 32'h5555);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        wr(A_KEY, 32'hAAAA);
        wr(A_KEY, 32'h5555);      // lands while pending
        wait_clear(4);
        rd(A_KEY, v);
        chk("R4 ignored key word", v, 32'hAAAA);
        running("R4 still running", 1'b1);
        key(32'h5555);
        running("R5 stopped", 1'b0);
    endtask

    task automatic t_enable();
        key(32'hBBBB);
        key(32'h5555);
        running("R6 stray word stays stopped", 1'b0);
        key(32'h4444);
        running("R6 lone second word", 1'b0);
        key(32'hBBBB);
        key(32'h4444);
        running("R7 restarted", 1'b1);
    endtask

    task automatic t_expire();
        logic [31:0] v;
        int n;
        wr(A_LOAD, 32'hFFFFFFF0);
        wait_clear(2);
        wr(A_TRIG, 32'd0);
        wait_clear(3);
        rd(A_CNT, v);
        chk("R10 reload near top", {31'd0, (v >= 32'hFFFFFFF0 && v < 32'hFFFFFFF8)}, 32'd1);
        n = int'(33'h1_0000_0000 - {1'b0, v});
        repeat (n - 1) @(negedge clk);
        chk("R8 before wrap", {31'd0, rst_req}, 32'd0);
        @(negedge clk);
        chk("R8 wrap edge", {31'd0, rst_req}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R8 pulse last cycle", {31'd0, rst_req}, 32'd1);
        rd(A_CNT, v);
        chk("R8 reload count", v, 32'hFFFFFFF3);
        @(negedge clk);
        chk("R8 pulse end", {31'd0, rst_req}, 32'd0);
        rd(A_CNT, v);
        chk("R8 keeps running", v, 32'hFFFFFFF4);
    endtask

    task automatic t_stopped();
        logic [31:0] v;
        int seen;
        key(32'hAAAA);
        key(32'h5555);
        repeat (6) @(negedge clk);
        wr(A_TRIG, 32'd0);
        wait_clear(3);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        chk("R9 no request when stopped", seen, 0);
        rd(A_CNT, v);
        chk("R9 count held", v, 32'hFFFFFFF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_pending();
        t_bad_seq();
        t_ignore();
        t_enable();
        t_expire();
        t_stopped();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule